// File: doc/BRIEF.md
# Block-Grouped Pixel Hit Address Readout

This block is the periphery side of a data-driven pixel readout. The pixel matrix is divided into square groups (8x8 pixels each, sixteen groups by default). Each group raises a single active-low request line when any of its pixels holds a hit. The readout picks one requesting group, enables that group's drivers onto a shared bus, latches what the bus carries and then pulses a reset back into that group so that its hits are cleared. The bus has eight column-pattern lines, eight row-pattern lines and a 4-bit group number, which is 20 lines in all.

Arbitration is fixed priority: the requesting group with the lowest number goes first. One readout takes two clocks. The first clock enables the group's drivers and the bus is latched at its end. The second clock drives that group's reset. While the reset clock runs, the next winner is chosen from the other groups, so back-to-back readouts follow each other without an idle clock. Every latch produces an output record made of the group number and the column and row patterns, marked by a one-cycle valid strobe. The block is modelled synchronously for a 40 MHz readout clock serving 1024 pixels.

Top module: `pixro_readout`

## Requirements
- R1: While `rst` is high, and in the first clock after it, `addr_en`, `pix_rst` and `rec_valid` are all zero, and a reset applied part-way through a readout abandons it.
- R2: A request is active when its `blk_req_n` bit is 0. When every bit is 1 and nothing is in progress, no `addr_en` bit is raised.
- R3: From idle, the first group granted is the lowest-numbered group whose request is 0. Bit i of `addr_en` is group i.
- R4: `addr_en` has at most one bit set and stays high for exactly one clock. In the next clock, `pix_rst` carries the same single bit for exactly one clock.
- R5: In the clock after an `addr_en` clock, `rec_valid` is 1 for one clock, and `rec_blk`, `rec_x` and `rec_y` equal the values that `line_blk`, `line_x` and `line_y` had during the `addr_en` clock.
- R6: If another group is still requesting during a `pix_rst` clock, the next lowest-numbered such group gets `addr_en` in the very next clock, so consecutive readouts are spaced two clocks apart.
- R7: Readout repeats until no request remains. Each group that was requesting is read exactly once, in ascending order, and the block then goes idle with `addr_en` and `rec_valid` at zero.
- R8: `addr_en` and `pix_rst` are never active in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst | input | 1 | Synchronous reset, active high |
| blk_req_n | input | NUM_BLK | Per-group hit OR, active low |
| line_x | input | XW | Shared column-pattern lines from the enabled group |
| line_y | input | YW | Shared row-pattern lines from the enabled group |
| line_blk | input | AW | Group number driven by the enabled group |
| addr_en | output | NUM_BLK | One-hot driver enable to the selected group |
| pix_rst | output | NUM_BLK | One-hot hit-clear pulse to the group just read |
| rec_valid | output | 1 | Record strobe, one clock per readout |
| rec_blk | output | AW | Latched group number |
| rec_x | output | XW | Latched column pattern |
| rec_y | output | YW | Latched row pattern |

## Verification
The assertions assume that the matrix behaves like a real group. A group drives the shared lines only while its enable bit is set. Its request stays low until its reset pulse and goes high after that pulse. No group picks up a new hit while it is being read. The bench models the matrix this way: each group holds a hit flag and fixed patterns, the flag is cleared on the falling edge that follows its reset pulse, and new hit sets are loaded only once the block has gone idle. The only exception is the mid-readout reset case, where the remaining hits are kept and must drain in order after the reset is released.

// File: rtl/pixro_pkg.sv
package pixro_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GRANT = 2'd1,
    ST_CLEAR = 2'd2
  } ro_state_t;
endpackage

// File: rtl/pixro_arbiter.sv
// Fixed-priority pick of the lowest-numbered active request outside the mask.
module pixro_arbiter #(
  parameter int NUM_BLK = 16,
  parameter int AW      = $clog2(NUM_BLK)
) (
  input  logic [NUM_BLK-1:0] req,
  input  logic [NUM_BLK-1:0] mask,
  output logic               any,
  output logic [AW-1:0]      win_idx,
  output logic [NUM_BLK-1:0] win_oh
);
  logic [NUM_BLK-1:0] eff;
  logic [NUM_BLK-1:0] below;

  assign eff = req & ~mask;
  assign any = |eff;

  // below[i] is set when some lower-numbered request is active
  assign below[0] = 1'b0;
  genvar g;
  generate
    for (g = 1; g < NUM_BLK; g++) begin : g_chain
      assign below[g] = below[g-1] | eff[g-1];
    end
  endgenerate

  assign win_oh = eff & ~below;

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < NUM_BLK; i++) begin
      if (win_oh[i]) win_idx = AW'(i);
    end
  end
endmodule

// File: rtl/pixro_seq.sv
// Two-clock enable/reset sequencer with look-ahead selection.
module pixro_seq
  import pixro_pkg::*;
#(
  parameter int NUM_BLK = 16,
  parameter int AW      = $clog2(NUM_BLK)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               any,
  input  logic [AW-1:0]      win_idx,
  input  logic [NUM_BLK-1:0] win_oh,
  output ro_state_t          state,
  output logic [NUM_BLK-1:0] sel_oh,
  output logic [NUM_BLK-1:0] addr_en,
  output logic [NUM_BLK-1:0] pix_rst
);
  logic [AW-1:0] sel;

  genvar g;
  generate
    for (g = 0; g < NUM_BLK; g++) begin : g_dec
      assign sel_oh[g] = (sel == AW'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      sel     <= '0;
      addr_en <= '0;
      pix_rst <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          pix_rst <= '0;
          if (any) begin
            sel     <= win_idx;
            addr_en <= win_oh;
            state   <= ST_GRANT;
          end
        end
        ST_GRANT: begin
          addr_en <= '0;
          pix_rst <= sel_oh;
          state   <= ST_CLEAR;
        end
        ST_CLEAR: begin
          pix_rst <= '0;
          if (any) begin
            sel     <= win_idx;
            addr_en <= win_oh;
            state   <= ST_GRANT;
          end else begin
            state   <= ST_IDLE;
          end
        end
        default: begin
          addr_en <= '0;
          pix_rst <= '0;
          state   <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/pixro_capture.sv
// Latches the shared address lines into an output record.
module pixro_capture #(
  parameter int AW = 4,
  parameter int XW = 8,
  parameter int YW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap,
  input  logic [AW-1:0] line_blk,
  input  logic [XW-1:0] line_x,
  input  logic [YW-1:0] line_y,
  output logic          rec_valid,
  output logic [AW-1:0] rec_blk,
  output logic [XW-1:0] rec_x,
  output logic [YW-1:0] rec_y
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rec_valid <= 1'b0;
      rec_blk   <= '0;
      rec_x     <= '0;
      rec_y     <= '0;
    end else begin
      rec_valid <= cap;
      if (cap) begin
        rec_blk <= line_blk;
        rec_x   <= line_x;
        rec_y   <= line_y;
      end
    end
  end
endmodule

// File: rtl/pixro_readout.sv
module pixro_readout
  import pixro_pkg::*;
#(
  parameter int NUM_BLK = 16,
  parameter int XW      = 8,
  parameter int YW      = 8,
  localparam int AW     = $clog2(NUM_BLK)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_BLK-1:0] blk_req_n,
  input  logic [XW-1:0]      line_x,
  input  logic [YW-1:0]      line_y,
  input  logic [AW-1:0]      line_blk,
  output logic [NUM_BLK-1:0] addr_en,
  output logic [NUM_BLK-1:0] pix_rst,
  output logic               rec_valid,
  output logic [AW-1:0]      rec_blk,
  output logic [XW-1:0]      rec_x,
  output logic [YW-1:0]      rec_y
);
  ro_state_t          state;
  logic [NUM_BLK-1:0] sel_oh;
  logic [NUM_BLK-1:0] mask;
  logic               any;
  logic [AW-1:0]      win_idx;
  logic [NUM_BLK-1:0] win_oh;

  // The group being cleared still shows its request; hide it.
  assign mask = (state == ST_CLEAR) ? sel_oh : '0;

  pixro_arbiter #(.NUM_BLK(NUM_BLK), .AW(AW)) u_arb (
    .req     (~blk_req_n),
    .mask    (mask),
    .any     (any),
    .win_idx (win_idx),
    .win_oh  (win_oh)
  );

  pixro_seq #(.NUM_BLK(NUM_BLK), .AW(AW)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .any     (any),
    .win_idx (win_idx),
    .win_oh  (win_oh),
    .state   (state),
    .sel_oh  (sel_oh),
    .addr_en (addr_en),
    .pix_rst (pix_rst)
  );

  pixro_capture #(.AW(AW), .XW(XW), .YW(YW)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .cap       (state == ST_GRANT),
    .line_blk  (line_blk),
    .line_x    (line_x),
    .line_y    (line_y),
    .rec_valid (rec_valid),
    .rec_blk   (rec_blk),
    .rec_x     (rec_x),
    .rec_y     (rec_y)
  );
endmodule

// File: rtl/pixro_readout_chk.sv
module pixro_readout_chk #(
  parameter int NUM_BLK = 16,
  parameter int XW      = 8,
  parameter int YW      = 8,
  parameter int AW      = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_BLK-1:0] blk_req_n,
  input logic [XW-1:0]      line_x,
  input logic [YW-1:0]      line_y,
  input logic [AW-1:0]      line_blk,
  input logic [NUM_BLK-1:0] addr_en,
  input logic [NUM_BLK-1:0] pix_rst,
  input logic               rec_valid,
  input logic [AW-1:0]      rec_blk,
  input logic [XW-1:0]      rec_x,
  input logic [YW-1:0]      rec_y
);
  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    rst |=> (addr_en == '0 && pix_rst == '0 && !rec_valid));

  // R2
  no_req_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_en == '0 && pix_rst == '0 && (&blk_req_n)) |=> addr_en == '0);

  // R3
  grant_requested_chk: assert property (@(posedge clk) disable iff (rst)
    (|addr_en) |-> ((addr_en & ~$past(blk_req_n)) != '0));

  // R4
  en_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(addr_en) && $onehot0(pix_rst));

  // R4
  en_then_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (|addr_en) |=> (pix_rst == $past(addr_en) && addr_en == '0));

  // R5
  record_chk: assert property (@(posedge clk) disable iff (rst)
    (|addr_en) |=> (rec_valid && rec_blk == $past(line_blk) &&
                    rec_x == $past(line_x) && rec_y == $past(line_y)));

  // R5
  record_only_after_en_chk: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> (pix_rst != '0));

  // R8
  en_rst_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !((|addr_en) && (|pix_rst)));
endmodule

bind pixro_readout pixro_readout_chk #(
  .NUM_BLK(NUM_BLK), .XW(XW), .YW(YW), .AW(AW)
) u_chk (
  .clk(clk), .rst(rst), .blk_req_n(blk_req_n),
  .line_x(line_x), .line_y(line_y), .line_blk(line_blk),
  .addr_en(addr_en), .pix_rst(pix_rst), .rec_valid(rec_valid),
  .rec_blk(rec_blk), .rec_x(rec_x), .rec_y(rec_y)
);

// File: tb/pixro_readout_test.sv
module pixro_readout_test;
  localparam int NB = 16;
  localparam int XW = 8;
  localparam int YW = 8;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [NB-1:0] hit = '0;
  logic [XW-1:0] hx [NB];
  logic [YW-1:0] hy [NB];
  logic [NB-1:0] blk_req_n;
  logic [XW-1:0] line_x;
  logic [YW-1:0] line_y;
  logic [AW-1:0] line_blk;
  logic [NB-1:0] addr_en, pix_rst;
  logic          rec_valid;
  logic [AW-1:0] rec_blk;
  logic [XW-1:0] rec_x;
  logic [YW-1:0] rec_y;

  int checks = 0;
  int errors = 0;

  assign blk_req_n = ~hit;

  // Matrix model: the enabled group drives the shared lines.
  always_comb begin
    line_x = '0; line_y = '0; line_blk = '0;
    for (int i = 0; i < NB; i++) begin
      if (addr_en[i]) begin
        line_x   = line_x | hx[i];
        line_y   = line_y | hy[i];
        line_blk = line_blk | AW'(i);
      end
    end
  end

  // Hits of a group are cleared by its reset pulse.
  always @(negedge clk) begin
    for (int i = 0; i < NB; i++) if (pix_rst[i]) hit[i] <= 1'b0;
  end

  pixro_readout #(.NUM_BLK(NB), .XW(XW), .YW(YW)) uut (
    .clk(clk), .rst(rst), .blk_req_n(blk_req_n),
    .line_x(line_x), .line_y(line_y), .line_blk(line_blk),
    .addr_en(addr_en), .pix_rst(pix_rst), .rec_valid(rec_valid),
    .rec_blk(rec_blk), .rec_x(rec_x), .rec_y(rec_y)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [NB-1:0] pat);
    for (int i = 0; i < NB; i++) begin
      hx[i] = XW'(i * 37 + int'(pat[7:0]));
      hy[i] = YW'(~(i * 11 + int'(pat[15:8])));
    end
    hit = pat;
  endtask

  // Expect every set bit of pat read in ascending order, two clocks apart.
  task automatic drain(input logic [NB-1:0] pat);
    bit first = 1'b1;
    for (int b = 0; b < NB; b++) begin
      if (pat[b]) begin
        @(negedge clk);
        chk(addr_en == NB'(1) << b, first ? "R3 grant" : "R6 next grant",
            32'(addr_en), 32'(NB'(1) << b));
        first = 1'b0;
        @(negedge clk);
        chk(pix_rst == NB'(1) << b, "R4 clear", 32'(pix_rst), 32'(NB'(1) << b));
        chk(addr_en == '0, "R8 exclusive", 32'(addr_en), 0);
        chk(rec_valid && rec_blk == AW'(b), "R5 blk",
            {rec_valid, 27'd0, rec_blk}, {1'b1, 27'd0, AW'(b)});
        chk(rec_x == hx[b] && rec_y == hy[b], "R5 pattern",
            {16'd0, rec_x, rec_y}, {16'd0, hx[b], hy[b]});
      end
    end
    @(negedge clk);
    chk(addr_en == '0 && !rec_valid, "R7 idle",
        {rec_valid, 15'd0, addr_en}, 0);
    chk(hit == '0, "R7 all read", 32'(hit), 0);
  endtask

  task automatic run(input logic [NB-1:0] pat);
    @(negedge clk);
    load(pat);
    if (pat == '0) begin
      repeat (3) begin
        @(negedge clk);
        chk(addr_en == '0 && pix_rst == '0, "R2 no request",
            {addr_en, pix_rst}, 0);
      end
    end else begin
      drain(pat);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [NB-1:0] rest;
    load('0);
    repeat (3) @(negedge clk);
    chk(addr_en == '0 && pix_rst == '0 && !rec_valid, "R1 reset",
        {rec_valid, 15'd0, addr_en}, 0);
    rst = 1'b0;

    run('0);
    run('1);
    for (int b = 0; b < NB; b++) run(NB'(1) << b);
    for (int m = 0; m < 256; m++) run({8'(m), ~8'(m)});
    run(16'h8001);
    run('0);

    // Reset part-way through a readout: remaining groups drain afterwards.
    @(negedge clk);
    load(16'h0F00);
    @(negedge clk);
    chk(addr_en == 16'h0100, "R3 grant", 32'(addr_en), 32'h0100);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(addr_en == '0 && pix_rst == '0 && !rec_valid, "R1 mid reset",
        {rec_valid, 15'd0, pix_rst}, 0);
    rest = hit;
    chk(rest == 16'h0E00, "R1 mid reset hits", 32'(rest), 32'h0E00);
    rst = 1'b0;
    drain(rest);
    run('0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule